// File: doc/BRIEF.md
# Descriptor Work-Queue Portal

This block is the device-side intake of a memory-mapped portal page that receives 64-byte command descriptors. Each descriptor arrives as a single-beat write carrying its address, its byte count and the full payload. A flag on the write selects the target queue. Plain writes go to a dedicated queue, which returns no status. Enqueue-command writes go to a shared queue, which returns an accept or reject status one cycle later. A sender can therefore tell when its descriptor was refused because the shared queue was full, and can retry it.

The portal occupies one 4 KiB page, selected by the upper address bits. The page holds 64 slots of 64 bytes. Every slot feeds the same queue, so a sender may stripe consecutive writes across slots. Writes that are not whole, aligned 64-byte descriptors inside the page are discarded. The intake takes one write per cycle with no backpressure. Each queue drains in arrival order on its own valid/ready output. A descriptor written to a full dedicated queue is discarded and counted in a drop counter.

Top module: `desc_portal`

## Requirements
- R1: After reset both queues are empty (`dq_valid` and `sq_valid` low), `rsp_valid` is low and `dq_drop_cnt` is zero.
- R2: A write with `wr_len` equal to 64, address bits [5:0] zero, page bits matching `PAGE_SEL` and `wr_enq` low enters the dedicated queue. It shows on `dq_data` with the same payload right after the accepting clock edge.
- R3: A write whose `wr_len` is not 64 is discarded. It produces no response, no queue entry and no counter change.
- R4: A write with nonzero address bits [5:0], or with address bits [ADDR_W-1:12] not equal to `PAGE_SEL`, is discarded in the same way.
- R5: Address bits [11:6] (the slot number) have no effect. Writes to any slot reach the same queue in the order they arrive.
- R6: A well-formed write with `wr_enq` high raises `rsp_valid` for exactly one cycle after its accepting edge. `rsp_accept` is high when the shared queue had room, and the descriptor is then queued.
- R7: A well-formed enqueue-command write that meets a full shared queue returns `rsp_valid` with `rsp_accept` low. It leaves the shared queue's contents unchanged.
- R8: A well-formed plain write that meets a full dedicated queue is discarded. `dq_drop_cnt` then rises by one and saturates at its all-ones value.
- R9: Each queue delivers descriptors first in, first out. While `valid` is high and `ready` is low, its data stays stable.
- R10: Writes on consecutive cycles are all taken without any wait, until the target queue reaches its depth.
- R11: Fullness is judged on the occupancy before the same-cycle pop. A write that meets a full queue is refused even when an entry leaves in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Inbound write present this cycle |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_len | input | LEN_W | Byte count of the write |
| wr_enq | input | 1 | High for an enqueue-command write (shared queue) |
| wr_data | input | DATA_W | Descriptor payload |
| rsp_valid | output | 1 | Status for an enqueue-command write |
| rsp_accept | output | 1 | 1 = descriptor queued, 0 = rejected |
| dq_valid | output | 1 | Dedicated queue has a descriptor |
| dq_ready | input | 1 | Engine takes the dedicated-queue head |
| dq_data | output | DATA_W | Dedicated-queue head descriptor |
| sq_valid | output | 1 | Shared queue has a descriptor |
| sq_ready | input | 1 | Engine takes the shared-queue head |
| sq_data | output | DATA_W | Shared-queue head descriptor |
| dq_drop_cnt | output | CNT_W | Count of plain writes dropped on a full dedicated queue |

## Verification
The bench builds the block with both queue depths set to 4 and a 3-bit drop counter. With these values, five back-to-back writes fill a queue and then overflow it. Nine dropped writes then carry the counter past its all-ones value, so saturation is reached within a few dozen cycles. The page selector is 3 on a 16-bit address, so the vector table can include a write aimed just outside the portal page. Holding one ready input low while the other is high separates the two queues, and it lets a pop and a rejected write fall on the same edge.

// File: rtl/portal_pkg.sv
package portal_pkg;

   typedef enum logic [1:0] {
      RT_NONE = 2'd0,
      RT_DED  = 2'd1,
      RT_SHR  = 2'd2
   } route_e;

   function automatic bit is_pow2(input int v);
      return (v > 1) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/portal_decode.sv
module portal_decode
   import portal_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int PAGE_BITS  = 12,
   parameter int DESC_BYTES = 64,
   parameter int LEN_W      = 7,
   parameter logic [ADDR_W-PAGE_BITS-1:0] PAGE_SEL = '0
) (
   input  logic              valid,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  len,
   input  logic              enq,
   output route_e            route
);
   localparam int SLOT_BITS = $clog2(DESC_BYTES);

   logic in_page;
   logic aligned;
   logic whole;
   logic unused_slot_bits;

   assign in_page          = (addr[ADDR_W-1:PAGE_BITS] == PAGE_SEL);
   assign aligned          = (addr[SLOT_BITS-1:0] == '0);
   assign whole            = (len == LEN_W'(DESC_BYTES));
   // slot number only spreads traffic; it never steers it
   assign unused_slot_bits = ^addr[PAGE_BITS-1:SLOT_BITS];

   always_comb begin
      route = RT_NONE;
      if (valid && in_page && aligned && whole) begin
         route = enq ? RT_SHR : RT_DED;
      end
   end
endmodule

// File: rtl/desc_fifo.sv
module desc_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 512
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [W-1:0]               push_data,
   output logic                       full,
   output logic                       out_valid,
   input  logic                       out_ready,
   output logic [W-1:0]               out_data,
   output logic [$clog2(DEPTH+1)-1:0] count
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr;
   logic [PW-1:0] rd_ptr;
   logic          do_push;
   logic          do_pop;

   assign full      = (count == CW'(DEPTH));
   assign out_valid = (count != '0);
   assign out_data  = mem[rd_ptr];
   assign do_push   = push && !full;
   assign do_pop    = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   p_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   generate
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   cnt <= '0;
            else if (inc && (cnt != '1))  cnt <= cnt + 1'b1;
         end
         p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt == '1) |=> (cnt == '1));
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt <= '0;
            else if (inc)  cnt <= cnt + 1'b1;
         end
      end
   endgenerate

   p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/desc_portal.sv
module desc_portal
   import portal_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int PAGE_BITS  = 12,
   parameter int DESC_BYTES = 64,
   parameter int DQ_DEPTH   = 16,
   parameter int SQ_DEPTH   = 16,
   parameter int CNT_W      = 16,
   parameter bit DROP_SAT   = 1'b1,
   parameter logic [ADDR_W-PAGE_BITS-1:0] PAGE_SEL = 'h3,
   localparam int DATA_W    = DESC_BYTES * 8,
   localparam int LEN_W     = $clog2(DESC_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [LEN_W-1:0]  wr_len,
   input  logic              wr_enq,
   input  logic [DATA_W-1:0] wr_data,
   output logic              rsp_valid,
   output logic              rsp_accept,
   output logic              dq_valid,
   input  logic              dq_ready,
   output logic [DATA_W-1:0] dq_data,
   output logic              sq_valid,
   input  logic              sq_ready,
   output logic [DATA_W-1:0] sq_data,
   output logic [CNT_W-1:0]  dq_drop_cnt
);
   localparam int SLOT_BITS = $clog2(DESC_BYTES);
   localparam int DQ_CW     = $clog2(DQ_DEPTH + 1);
   localparam int SQ_CW     = $clog2(SQ_DEPTH + 1);

   generate
      if (!is_pow2(DQ_DEPTH) || !is_pow2(SQ_DEPTH)) begin : g_bad_depth
         $error("queue depths must be powers of two, at least 2");
      end
      if (!is_pow2(DESC_BYTES) || PAGE_BITS <= SLOT_BITS) begin : g_bad_slot
         $error("descriptor size must be a power of two below the page size");
      end
      if (ADDR_W <= PAGE_BITS || CNT_W < 1) begin : g_bad_width
         $error("address must exceed page bits and counter width be positive");
      end
   endgenerate

   route_e            route;
   logic              dq_push;
   logic              sq_push;
   logic              dq_full;
   logic              sq_full;
   logic [DQ_CW-1:0]  dq_count;
   logic [SQ_CW-1:0]  sq_count;

   portal_decode #(
      .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .DESC_BYTES(DESC_BYTES),
      .LEN_W(LEN_W), .PAGE_SEL(PAGE_SEL)
   ) u_dec (
      .valid(wr_valid), .addr(wr_addr), .len(wr_len), .enq(wr_enq),
      .route(route)
   );

   assign dq_push = (route == RT_DED);
   assign sq_push = (route == RT_SHR);

   desc_fifo #(.DEPTH(DQ_DEPTH), .W(DATA_W)) u_dq (
      .clk(clk), .rst_n(rst_n), .push(dq_push), .push_data(wr_data),
      .full(dq_full), .out_valid(dq_valid), .out_ready(dq_ready),
      .out_data(dq_data), .count(dq_count)
   );

   desc_fifo #(.DEPTH(SQ_DEPTH), .W(DATA_W)) u_sq (
      .clk(clk), .rst_n(rst_n), .push(sq_push), .push_data(wr_data),
      .full(sq_full), .out_valid(sq_valid), .out_ready(sq_ready),
      .out_data(sq_data), .count(sq_count)
   );

   sat_counter #(.CNT_W(CNT_W), .SATURATE(DROP_SAT)) u_drop (
      .clk(clk), .rst_n(rst_n), .inc(dq_push && dq_full), .cnt(dq_drop_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_accept <= 1'b0;
      end else begin
         rsp_valid  <= sq_push;
         rsp_accept <= sq_push && !sq_full;
      end
   end

   p_rsp_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(wr_valid && wr_enq));

   p_accept_grow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_accept) |->
         (int'(sq_count) == int'($past(sq_count)) + 1 - int'($past(sq_valid && sq_ready))));

   p_reject_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_accept) |-> ($past(sq_count) == SQ_CW'(SQ_DEPTH)));

   p_short_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && (wr_len != LEN_W'(DESC_BYTES)) && !(dq_valid && dq_ready))
         |=> (dq_count == $past(dq_count) && !rsp_valid));

   p_misalign_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && (wr_addr[SLOT_BITS-1:0] != '0)) |=> !rsp_valid);
endmodule

// File: tb/sim_desc_portal.sv
module sim_desc_portal;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int AW = 16;
   localparam int DW = 512;
   localparam int LW = 7;
   localparam int CW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [LW-1:0] wr_len = '0;
   logic          wr_enq = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          rsp_valid, rsp_accept;
   logic          dq_valid, sq_valid;
   logic          dq_ready = 1'b0;
   logic          sq_ready = 1'b0;
   logic [DW-1:0] dq_data, sq_data;
   logic [CW-1:0] dq_drop_cnt;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   desc_portal #(
      .ADDR_W(AW), .PAGE_BITS(12), .DESC_BYTES(64), .DQ_DEPTH(4),
      .SQ_DEPTH(4), .CNT_W(CW), .DROP_SAT(1'b1), .PAGE_SEL(4'h3)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_len(wr_len), .wr_enq(wr_enq), .wr_data(wr_data),
      .rsp_valid(rsp_valid), .rsp_accept(rsp_accept),
      .dq_valid(dq_valid), .dq_ready(dq_ready), .dq_data(dq_data),
      .sq_valid(sq_valid), .sq_ready(sq_ready), .sq_data(sq_data),
      .dq_drop_cnt(dq_drop_cnt)
   );

   // vector: {enq, len[6:0], addr[15:0], tag[7:0], kind[1:0]}
   // kind: 0 = discarded, 1 = dedicated queue, 2 = shared queue accepted
   localparam int NV = 11;
   localparam logic [33:0] VEC [NV] = '{
      {1'b0, 7'd64, 16'h3000, 8'hA1, 2'd1},  // R2
      {1'b0, 7'd64, 16'h3FC0, 8'hA2, 2'd1},  // R5 last slot
      {1'b0, 7'd32, 16'h3040, 8'hA3, 2'd0},  // R3 short
      {1'b1, 7'd64, 16'h3080, 8'hA4, 2'd2},  // R6
      {1'b1, 7'd63, 16'h30C0, 8'hA5, 2'd0},  // R3 short enq
      {1'b0, 7'd64, 16'h3044, 8'hA6, 2'd0},  // R4 misaligned
      {1'b1, 7'd64, 16'h3101, 8'hA7, 2'd0},  // R4 misaligned enq
      {1'b1, 7'd64, 16'h37C0, 8'hA8, 2'd2},  // R5 other slot, shared
      {1'b0, 7'd0,  16'h3000, 8'hA9, 2'd0},  // R3 zero length
      {1'b0, 7'd64, 16'h4540, 8'hAA, 2'd0},  // R4 outside page
      {1'b0, 7'd64, 16'h3540, 8'hAB, 2'd1}   // R2
   };

   function automatic logic [DW-1:0] pay(input logic [7:0] tag);
      return {64{tag}};
   endfunction

   task automatic chk(input bit ok, input string req,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input bit enq, input logic [6:0] len,
                        input logic [15:0] addr, input logic [7:0] tag);
      wr_valid = 1'b1;
      wr_enq   = enq;
      wr_len   = len;
      wr_addr  = addr;
      wr_data  = pay(tag);
   endtask

   task automatic write1(input bit enq, input logic [6:0] len,
                         input logic [15:0] addr, input logic [7:0] tag);
      @(negedge clk);
      drive(enq, len, addr, tag);
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!dq_valid && !sq_valid && !rsp_valid, "R1 outputs in reset",
          {dq_valid, sq_valid, rsp_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!dq_valid && !sq_valid && !rsp_valid && dq_drop_cnt == 0,
          "R1 after reset", {dq_valid, sq_valid, rsp_valid, dq_drop_cnt}, 0);

      // table walk, both queues draining
      dq_ready = 1'b1;
      sq_ready = 1'b1;
      for (int i = 0; i < NV; i++) begin
         logic [33:0] v;
         v = VEC[i];
         write1(v[33], v[32:26], v[25:10], v[9:2]);
         case (v[1:0])
            2'd1: chk(dq_valid && dq_data == pay(v[9:2]) && !sq_valid && !rsp_valid,
                      "R2/R5 dedicated entry", dq_data[63:0], pay(v[9:2]) >> 448);
            2'd2: chk(sq_valid && sq_data == pay(v[9:2]) && rsp_valid && rsp_accept && !dq_valid,
                      "R6/R5 shared accept", {sq_valid, rsp_valid, rsp_accept, sq_data[7:0]},
                      {3'b111, v[9:2]});
            default: chk(!dq_valid && !sq_valid && !rsp_valid && dq_drop_cnt == 0,
                      "R3/R4 discarded write", {dq_valid, sq_valid, rsp_valid}, 0);
         endcase
      end
      @(negedge clk);
      chk(!rsp_valid, "R6 response lasts one cycle", rsp_valid, 0);

      // dedicated queue: back-to-back fill, overflow, saturation, order
      dq_ready = 1'b0;
      sq_ready = 1'b0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         drive(1'b0, 7'd64, 16'h3000 + 16'(i * 64), 8'hB0 + 8'(i));
      end
      @(negedge clk);
      wr_valid = 1'b0;
      chk(dq_drop_cnt == 1, "R8 fifth write dropped", dq_drop_cnt, 1);
      chk(dq_valid && dq_data == pay(8'hB0), "R10 back-to-back head",
          dq_data[7:0], 8'hB0);
      repeat (2) @(negedge clk);
      chk(dq_valid && dq_data == pay(8'hB0), "R9 head held without ready",
          dq_data[7:0], 8'hB0);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         drive(1'b0, 7'd64, 16'h3200, 8'hEE);
      end
      @(negedge clk);
      wr_valid = 1'b0;
      chk(dq_drop_cnt == 3'd7, "R8 counter saturates", dq_drop_cnt, 7);
      dq_ready = 1'b1;
      for (int k = 0; k < 4; k++) begin
         chk(dq_valid && dq_data == pay(8'hB0 + 8'(k)), "R9 dedicated order",
             dq_data[7:0], 8'hB0 + 8'(k));
         @(negedge clk);
      end
      chk(!dq_valid, "R8 dropped writes never appear", dq_valid, 0);
      dq_ready = 1'b0;

      // shared queue: fill, reject, same-cycle pop
      for (int i = 0; i < 4; i++) begin
         write1(1'b1, 7'd64, 16'h3000 + 16'(i * 128), 8'hC0 + 8'(i));
         chk(rsp_valid && rsp_accept, "R6 shared accept while room",
             {rsp_valid, rsp_accept}, 2'b11);
      end
      write1(1'b1, 7'd64, 16'h3040, 8'hC4);
      chk(rsp_valid && !rsp_accept, "R7 reject on full", {rsp_valid, rsp_accept}, 2'b10);
      chk(sq_data == pay(8'hC0), "R7 head unchanged", sq_data[7:0], 8'hC0);
      @(negedge clk);
      drive(1'b1, 7'd64, 16'h3080, 8'hC8);
      sq_ready = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0;
      sq_ready = 1'b0;
      chk(rsp_valid && !rsp_accept, "R11 reject despite same-cycle pop",
          {rsp_valid, rsp_accept}, 2'b10);
      chk(sq_valid && sq_data == pay(8'hC1), "R11 one entry left",
          sq_data[7:0], 8'hC1);
      sq_ready = 1'b1;
      for (int k = 1; k < 4; k++) begin
         chk(sq_valid && sq_data == pay(8'hC0 + 8'(k)), "R9 shared order",
             sq_data[7:0], 8'hC0 + 8'(k));
         @(negedge clk);
      end
      chk(!sq_valid, "R7 rejected descriptors absent", sq_valid, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule